// File: doc/BRIEF.md
# Serial Status-Readback Slave for a Two-Channel Switch Controller

This block is the serial-port slave of a two-channel high-side switch controller. While its chip select is low, a host clocks 8-bit command words into it. Each bit goes in on the rising edge of the serial clock. On the same clock, a status byte comes out of it, most significant bit first, changing on the falling edge. The status byte is captured at the moment chip select falls. Which status row it carries depends on two things that earlier valid frames left behind: the status-select setting, and the channel bit of the previous command. After the first byte has gone out, the output repeats the incoming stream with an 8-bit delay, so several devices can share one daisy chain.

When chip select rises, the block checks the frame length. It commits the last received byte to the addressed register only when the frame holds a whole, nonzero number of bytes. A frame of any other length changes nothing. The serial pins are brought into the system clock domain through synchronizer stages. The fault, pin and watchdog status arrive as plain inputs. A voltage-mask register can stop undervoltage and overvoltage from being reported in the fault row.

Top module: `spi_status_slave`

## Requirements
- R1: At the chip-select falling edge, the status byte selected by the stored state is captured into the output shift register. That byte is what the first eight bits of the frame return.
- R2: The captured byte is shifted out most significant bit first. The output advances by one bit after each falling edge of the serial clock.
- R3: Output bit k of a frame, for k of 8 or more, equals input bit k-8 of the same frame.
- R4: A command byte is laid out as: bit 7 = channel/flag bit, bits 6:4 = address, bits 3:0 = data. A frame is valid when it holds a nonzero multiple of 8 bits. When chip select rises on a valid frame, only its last byte is committed. The committed byte stores bit 7 as the channel bit and then writes by address:
  - 0: status select ← data[2:0]
  - 1: overcurrent field of channel bit 7 (cfg_oc)
  - 2: diagnostic field of channel bit 7 (cfg_diag)
  - 3: drive field of channel bit 7 (cfg_drv)
  - 4: enable field (cfg_en)
  - 5: watchdog field ← data[2:0] (cfg_wd)
  - 6: voltage mask (uv_dis ← data[1], ov_dis ← data[0])
  - 7: writes nothing

  In the per-channel outputs, channel c occupies bits [4c+3:4c].
- R5: A frame of any other length, including zero bits, leaves every register, the channel bit and the status select unchanged.
- R6: While chip select is high, spi_miso_oe is 0 and spi_miso is 0.
- R7: Bit 7 of the returned byte is the channel bit of the previous valid frame. The per-channel rows below describe that channel.
- R8: When the status select is s ≠ 0, the returned byte is {channel bit, s, row}. The 4-bit row is:
  - 1: cfg_en
  - 2: overcurrent field of the channel
  - 3: diagnostic field of the channel
  - 4: drive field of the channel
  - 5: {wd_timeout, cfg_wd}
  - 6: pin_lvl
  - 7: {0, 0, uv_dis, ov_dis}

  When s = 0, the returned byte is {channel bit, otf, ochf, oclf, olf, uv, ov, fault}. The four channel flags are ch_flags[4c+3:4c], in that order. fault is the OR of the other six bits.
- R9: uv is uv_flag AND NOT uv_dis, and ov is ov_flag AND NOT ov_dis. Both disables reset to 0.
- R10: Frames longer than the byte counter can count are still judged correctly: 520 bits is valid, 517 bits is invalid.
- R11: After reset, all registers, the channel bit and the status select are 0. The status select keeps its value until address 0 is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (tri-state control) |
| ch_flags | input | 8 | Per-channel {otf, ochf, oclf, olf}, channel c at [4c+3:4c] |
| uv_flag | input | 1 | Undervoltage condition |
| ov_flag | input | 1 | Overvoltage condition |
| wd_timeout | input | 1 | Watchdog timeout status |
| pin_lvl | input | 4 | Raw input pin levels |
| cfg_oc | output | 8 | Overcurrent fields, per channel |
| cfg_diag | output | 8 | Diagnostic fields, per channel |
| cfg_drv | output | 8 | Drive fields, per channel |
| cfg_en | output | 4 | Enable field |
| cfg_wd | output | 3 | Watchdog field |
| uv_dis | output | 1 | Undervoltage report disable |
| ov_dis | output | 1 | Overvoltage report disable |

## Verification
The assertions assume the following about the inputs:
- Serial clock edges and chip-select edges are separated by several system-clock cycles, so the synchronizers never see them in the same cycle.
- The serial clock is low whenever chip select changes.
- spi_mosi settles before the serial-clock rising edge that samples it.
- The status inputs are steady around the chip-select falling edge.

The bench drives each serial half period over eight system clocks and sets data two clocks before the rising edge. It leaves eight clocks of margin around every chip-select transition. It changes the status inputs only between frames, so every captured byte can be predicted from a bench-side model of the registers.

// File: rtl/spi_status_pkg.sv
// Shared types and constants for the serial status-readback slave.
// Assumes an 8-bit command word and exactly two switch channels.
package spi_status_pkg;
    localparam int WORD_W = 8;
    localparam int CH_N   = 2;
    localparam int FLD_W  = 4;
    localparam int WDF_W  = 3;

    // Register addresses carried in command bits 6:4.
    typedef enum logic [2:0] {
        RA_SEL   = 3'd0,
        RA_OC    = 3'd1,
        RA_DIAG  = 3'd2,
        RA_DRV   = 3'd3,
        RA_EN    = 3'd4,
        RA_WD    = 3'd5,
        RA_VMASK = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    // Command byte layout.
    typedef struct packed {
        logic       chsel;
        reg_addr_e  addr;
        logic [3:0] data;
    } cmd_t;
endpackage

// File: rtl/spi_edge_sync.sv
// Brings chip select, serial clock and serial data into the system clock
// domain through STAGES flip-flops each, then derives one-cycle edge strobes.
// Assumes the serial clock is much slower than clk and idles low while
// chip select changes. Serial-clock edges are reported only inside a frame.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_s,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] mosi_p;
    logic              cs_d;
    logic              sck_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First synchronizer stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cs_p[0]   <= 1'b1;
                        sck_p[0]  <= 1'b0;
                        mosi_p[0] <= 1'b0;
                    end else begin
                        cs_p[0]   <= cs_n;
                        sck_p[0]  <= sck;
                        mosi_p[0] <= mosi;
                    end
                end
            end else begin : g_next
                // Later stages follow the stage before.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cs_p[g]   <= 1'b1;
                        sck_p[g]  <= 1'b0;
                        mosi_p[g] <= 1'b0;
                    end else begin
                        cs_p[g]   <= cs_p[g-1];
                        sck_p[g]  <= sck_p[g-1];
                        mosi_p[g] <= mosi_p[g-1];
                    end
                end
            end
        end
    endgenerate

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_p[STAGES-1];
            sck_d <= sck_p[STAGES-1];
        end
    end

    assign cs_s     = cs_p[STAGES-1];
    assign mosi_s   = mosi_p[STAGES-1];
    assign cs_fall  = cs_d & ~cs_s;
    assign cs_rise  = ~cs_d & cs_s;
    assign sck_rise = ~sck_d & sck_p[STAGES-1] & ~cs_s;
    assign sck_fall = sck_d & ~sck_p[STAGES-1] & ~cs_s;
endmodule

// File: rtl/spi_frame_shifter.sv
// Frame engine. It loads the status byte at the start of a frame and shifts
// it out on serial-clock falls, feeding received bits in behind it (8-bit
// delay line). It also collects received bits and counts bits modulo the
// word size plus whole bytes (saturating). At frame end it issues a commit
// strobe when the length is a nonzero whole number of words.
// Assumes WORD_W is a power of two.
module spi_frame_shifter #(
    parameter int WORD_W = 8,
    parameter int BCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] status_byte,
    output logic              load_stb,
    output logic              miso_bit,
    output logic [WORD_W-1:0] rx_byte,
    output logic [WORD_W-1:0] tx_shreg,
    output logic [BCNT_W-1:0] byte_cnt,
    output logic              frame_active,
    output logic              commit_stb
);
    localparam int                BIT_W    = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

    logic [BIT_W-1:0] bit_idx;
    logic             held_bit;
    logic             frame_ok;

    assign load_stb = cs_fall;
    assign miso_bit = tx_shreg[WORD_W-1];
    assign frame_ok = (bit_idx == '0) && (byte_cnt != '0);

    // Frame state: load, receive, shift out, count bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_shreg     <= '0;
            rx_byte      <= '0;
            held_bit     <= 1'b0;
            bit_idx      <= '0;
            byte_cnt     <= '0;
            frame_active <= 1'b0;
        end else if (cs_fall) begin
            tx_shreg     <= status_byte;
            held_bit     <= 1'b0;
            bit_idx      <= '0;
            byte_cnt     <= '0;
            frame_active <= 1'b1;
        end else if (cs_rise) begin
            frame_active <= 1'b0;
        end else if (frame_active) begin
            if (sck_rise) begin
                rx_byte  <= {rx_byte[WORD_W-2:0], mosi_s};
                held_bit <= mosi_s;
                bit_idx  <= bit_idx + 1'b1;
                if (bit_idx == LAST_BIT && byte_cnt != BCNT_MAX) begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
            end
            if (sck_fall) begin
                tx_shreg <= {tx_shreg[WORD_W-2:0], held_bit};
            end
        end
    end

    // One-cycle commit strobe for a well-formed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_stb <= 1'b0;
        end else begin
            commit_stb <= cs_rise & frame_active & frame_ok;
        end
    end
endmodule

// File: rtl/spi_reg_file.sv
// Configuration registers written by committed command bytes, and the
// multiplexer that forms the status byte from the stored select, the stored
// channel bit and the status inputs. Voltage faults pass through the mask
// before they reach the fault row.
// Assumes commit_stb is a single-cycle pulse with cmd_byte stable.
module spi_reg_file
    import spi_status_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_stb,
    input  logic [WORD_W-1:0]      cmd_byte,
    input  logic [CH_N*FLD_W-1:0]  ch_flags,
    input  logic                   uv_flag,
    input  logic                   ov_flag,
    input  logic                   wd_timeout,
    input  logic [FLD_W-1:0]       pin_lvl,
    output logic [WORD_W-1:0]      status_byte,
    output logic                   chsel,
    output logic [CH_N*FLD_W-1:0]  cfg_oc,
    output logic [CH_N*FLD_W-1:0]  cfg_diag,
    output logic [CH_N*FLD_W-1:0]  cfg_drv,
    output logic [FLD_W-1:0]       cfg_en,
    output logic [WDF_W-1:0]       cfg_wd,
    output logic                   uv_dis,
    output logic                   ov_dis,
    output logic                   uv_rep,
    output logic                   ov_rep
);
    cmd_t       cmd;
    logic [2:0] sel_q;
    logic [FLD_W-1:0] flags_c;
    logic [FLD_W-1:0] oc_c;
    logic [FLD_W-1:0] diag_c;
    logic [FLD_W-1:0] drv_c;
    logic [FLD_W-1:0] row;

    assign cmd = cmd_t'(cmd_byte);

    // Global registers: select, channel bit, enable, watchdog, voltage mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            chsel  <= 1'b0;
            cfg_en <= '0;
            cfg_wd <= '0;
            uv_dis <= 1'b0;
            ov_dis <= 1'b0;
        end else if (commit_stb) begin
            chsel <= cmd.chsel;
            case (cmd.addr)
                RA_SEL:   sel_q  <= cmd.data[2:0];
                RA_EN:    cfg_en <= cmd.data;
                RA_WD:    cfg_wd <= cmd.data[WDF_W-1:0];
                RA_VMASK: begin
                    uv_dis <= cmd.data[1];
                    ov_dis <= cmd.data[0];
                end
                default: ;
            endcase
        end
    end

    genvar c;
    generate
        for (c = 0; c < CH_N; c++) begin : g_ch
            logic [FLD_W-1:0] oc_q;
            logic [FLD_W-1:0] diag_q;
            logic [FLD_W-1:0] drv_q;
            logic             hit;

            assign hit = commit_stb && (cmd.chsel == c[0]);

            // Per-channel fields, written when the channel bit names this channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    oc_q   <= '0;
                    diag_q <= '0;
                    drv_q  <= '0;
                end else if (hit) begin
                    case (cmd.addr)
                        RA_OC:   oc_q   <= cmd.data;
                        RA_DIAG: diag_q <= cmd.data;
                        RA_DRV:  drv_q  <= cmd.data;
                        default: ;
                    endcase
                end
            end

            assign cfg_oc[c*FLD_W +: FLD_W]   = oc_q;
            assign cfg_diag[c*FLD_W +: FLD_W] = diag_q;
            assign cfg_drv[c*FLD_W +: FLD_W]  = drv_q;
        end
    endgenerate

    assign uv_rep = uv_flag & ~uv_dis;
    assign ov_rep = ov_flag & ~ov_dis;

    // Pick the fields of the channel named by the stored channel bit.
    always_comb begin
        flags_c = ch_flags[chsel*FLD_W +: FLD_W];
        oc_c    = cfg_oc[chsel*FLD_W +: FLD_W];
        diag_c  = cfg_diag[chsel*FLD_W +: FLD_W];
        drv_c   = cfg_drv[chsel*FLD_W +: FLD_W];
    end

    // Row content for the non-fault selections.
    always_comb begin
        case (sel_q)
            3'd1:    row = cfg_en;
            3'd2:    row = oc_c;
            3'd3:    row = diag_c;
            3'd4:    row = drv_c;
            3'd5:    row = {wd_timeout, cfg_wd};
            3'd6:    row = pin_lvl;
            3'd7:    row = {2'b00, uv_dis, ov_dis};
            default: row = '0;
        endcase
    end

    // Assemble the status byte.
    always_comb begin
        if (sel_q == 3'd0) begin
            status_byte = {chsel, flags_c, uv_rep, ov_rep,
                           (|flags_c) | uv_rep | ov_rep};
        end else begin
            status_byte = {chsel, sel_q, row};
        end
    end
endmodule

// File: rtl/spi_status_slave.sv
// Top level of the serial status-readback slave. It chains the pin
// synchronizer, the frame engine and the register file. The data output is
// driven only while the synchronized chip select is low.
// Assumes spi_sck idles low and is far slower than clk.
module spi_status_slave
    import spi_status_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BCNT_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_cs_n,
    input  logic                  spi_sck,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    input  logic [CH_N*FLD_W-1:0] ch_flags,
    input  logic                  uv_flag,
    input  logic                  ov_flag,
    input  logic                  wd_timeout,
    input  logic [FLD_W-1:0]      pin_lvl,
    output logic [CH_N*FLD_W-1:0] cfg_oc,
    output logic [CH_N*FLD_W-1:0] cfg_diag,
    output logic [CH_N*FLD_W-1:0] cfg_drv,
    output logic [FLD_W-1:0]      cfg_en,
    output logic [WDF_W-1:0]      cfg_wd,
    output logic                  uv_dis,
    output logic                  ov_dis
);
    logic              cs_s;
    logic              cs_fall;
    logic              cs_rise;
    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_s;
    logic              load_stb;
    logic              miso_bit;
    logic [WORD_W-1:0] rx_byte;
    logic [WORD_W-1:0] tx_shreg;
    logic [BCNT_W-1:0] byte_cnt;
    logic              frame_active;
    logic              commit_stb;
    logic [WORD_W-1:0] status_byte;
    logic              chsel;
    logic              uv_rep;
    logic              ov_rep;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_s     (cs_s),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    spi_frame_shifter #(.WORD_W(WORD_W), .BCNT_W(BCNT_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_fall      (cs_fall),
        .cs_rise      (cs_rise),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .mosi_s       (mosi_s),
        .status_byte  (status_byte),
        .load_stb     (load_stb),
        .miso_bit     (miso_bit),
        .rx_byte      (rx_byte),
        .tx_shreg     (tx_shreg),
        .byte_cnt     (byte_cnt),
        .frame_active (frame_active),
        .commit_stb   (commit_stb)
    );

    spi_reg_file u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_stb  (commit_stb),
        .cmd_byte    (rx_byte),
        .ch_flags    (ch_flags),
        .uv_flag     (uv_flag),
        .ov_flag     (ov_flag),
        .wd_timeout  (wd_timeout),
        .pin_lvl     (pin_lvl),
        .status_byte (status_byte),
        .chsel       (chsel),
        .cfg_oc      (cfg_oc),
        .cfg_diag    (cfg_diag),
        .cfg_drv     (cfg_drv),
        .cfg_en      (cfg_en),
        .cfg_wd      (cfg_wd),
        .uv_dis      (uv_dis),
        .ov_dis      (ov_dis),
        .uv_rep      (uv_rep),
        .ov_rep      (ov_rep)
    );

    assign spi_miso_oe = ~cs_s;
    assign spi_miso    = miso_bit & ~cs_s;
endmodule

// File: rtl/spi_status_slave_chk.sv
// Assertion checker attached to spi_status_slave. It relates frame-engine
// strobes to register-file state and the serial pins over time.
module spi_status_slave_chk #(
    parameter int BCNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              load_stb,
    input logic [7:0]        status_byte,
    input logic [7:0]        tx_shreg,
    input logic              chsel,
    input logic              commit_stb,
    input logic              frame_active,
    input logic [BCNT_W-1:0] byte_cnt,
    input logic [32:0]       cfg_vec,
    input logic              uv_dis,
    input logic              uv_rep,
    input logic              ov_dis,
    input logic              ov_rep
);
    // R1: the captured byte is the status byte of the load cycle.
    p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (tx_shreg == $past(status_byte)));

    // R7: the first output bit carries the stored channel bit.
    p_chsel_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (tx_shreg[7] == $past(chsel)));

    // R6: chip select high for three cycles means the output is released.
    p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2))
        |-> (!spi_miso_oe && !spi_miso));

    // R5: configuration changes only right after a commit strobe.
    p_cfg_only_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_vec) |-> $past(commit_stb));

    // R4: a commit happens only once the frame has ended.
    p_commit_after_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> !frame_active);

    // R10: the byte count never steps backwards within a frame.
    p_bytes_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && $past(frame_active)) |-> (byte_cnt >= $past(byte_cnt)));

    // R9: a disabled voltage condition is never reported.
    p_uv_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_dis |-> !uv_rep);
    p_ov_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ov_dis |-> !ov_rep);
endmodule

bind spi_status_slave spi_status_slave_chk #(.BCNT_W(BCNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_cs_n     (spi_cs_n),
    .spi_miso     (spi_miso),
    .spi_miso_oe  (spi_miso_oe),
    .load_stb     (load_stb),
    .status_byte  (status_byte),
    .tx_shreg     (tx_shreg),
    .chsel        (chsel),
    .commit_stb   (commit_stb),
    .frame_active (frame_active),
    .byte_cnt     (byte_cnt),
    .cfg_vec      ({cfg_oc, cfg_diag, cfg_drv, cfg_en, cfg_wd, uv_dis, ov_dis}),
    .uv_dis       (uv_dis),
    .uv_rep       (uv_rep),
    .ov_dis       (ov_dis),
    .ov_rep       (ov_rep)
);

// File: tb/spi_status_slave_tb.sv
// Self-checking bench. A register model tracks every frame, and each
// frame's returned byte, echo stream and register outputs are compared
// against it.
module spi_status_slave_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic [7:0] ch_flags = 8'h00;
    logic       uv_flag = 1'b0;
    logic       ov_flag = 1'b0;
    logic       wd_timeout = 1'b0;
    logic [3:0] pin_lvl = 4'h0;
    logic [7:0] cfg_oc, cfg_diag, cfg_drv;
    logic [3:0] cfg_en;
    logic [2:0] cfg_wd;
    logic       uv_dis, ov_dis;

    int total = 0;
    int bad = 0;

    // Register model.
    logic [2:0] m_sel = 0;
    logic       m_ch = 0;
    logic [3:0] m_oc[2];
    logic [3:0] m_diag[2];
    logic [3:0] m_drv[2];
    logic [3:0] m_en = 0;
    logic [2:0] m_wd = 0;
    logic       m_uvd = 0;
    logic       m_ovd = 0;

    spi_status_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .ch_flags(ch_flags), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .wd_timeout(wd_timeout), .pin_lvl(pin_lvl), .cfg_oc(cfg_oc),
        .cfg_diag(cfg_diag), .cfg_drv(cfg_drv), .cfg_en(cfg_en),
        .cfg_wd(cfg_wd), .uv_dis(uv_dis), .ov_dis(ov_dis)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [3:0] f;
        logic uvr, ovr;
        f   = ch_flags[m_ch*4 +: 4];
        uvr = uv_flag & ~m_uvd;
        ovr = ov_flag & ~m_ovd;
        case (m_sel)
            3'd0: return {m_ch, f, uvr, ovr, (f != 0) | uvr | ovr};
            3'd1: return {m_ch, m_sel, m_en};
            3'd2: return {m_ch, m_sel, m_oc[m_ch]};
            3'd3: return {m_ch, m_sel, m_diag[m_ch]};
            3'd4: return {m_ch, m_sel, m_drv[m_ch]};
            3'd5: return {m_ch, m_sel, wd_timeout, m_wd};
            3'd6: return {m_ch, m_sel, pin_lvl};
            default: return {m_ch, m_sel, 2'b00, m_uvd, m_ovd};
        endcase
    endfunction

    function automatic logic [32:0] model_cfg();
        return {m_oc[1], m_oc[0], m_diag[1], m_diag[0], m_drv[1], m_drv[0],
                m_en, m_wd, m_uvd, m_ovd};
    endfunction

    task automatic model_commit(input logic [7:0] b);
        m_ch = b[7];
        case (b[6:4])
            3'd0: m_sel = b[2:0];
            3'd1: m_oc[b[7]] = b[3:0];
            3'd2: m_diag[b[7]] = b[3:0];
            3'd3: m_drv[b[7]] = b[3:0];
            3'd4: m_en = b[3:0];
            3'd5: m_wd = b[2:0];
            3'd6: begin m_uvd = b[1]; m_ovd = b[0]; end
            default: ;
        endcase
    endtask

    function automatic logic sbit(input int i, input int n, input logic [7:0] body, input logic [7:0] last);
        logic [7:0] b;
        b = ((n % 8 == 0) && (i / 8 == n / 8 - 1)) ? last : body;
        return b[7 - (i % 8)];
    endfunction

    // One full frame with checks of return byte, echo, enable and registers.
    task automatic xfer(input int n, input logic [7:0] body, input logic [7:0] last, input string tag);
        logic [7:0] exp_b;
        logic [7:0] got;
        int ebad;
        int oebad;
        exp_b = exp_status();
        got = '0; ebad = 0; oebad = 0;
        spi_cs_n = 1'b0;
        tick(8);
        for (int i = 0; i < n; i++) begin
            logic ob;
            ob = spi_miso;
            if (spi_miso_oe !== 1'b1) oebad++;
            if (i < 8) got[7-i] = ob;
            else if (ob !== sbit(i - 8, n, body, last)) ebad++;
            spi_mosi = sbit(i, n, body, last);
            tick(2);
            spi_sck = 1'b1;
            tick(8);
            spi_sck = 1'b0;
            tick(8);
        end
        spi_cs_n = 1'b1;
        tick(8);
        if (n >= 8) check({tag, " R1/R2/R8 returned byte"}, got, exp_b);
        if (n >= 16) check({tag, " R3 echo mismatches"}, ebad, 0);
        if (n >= 1) check({tag, " oe in frame"}, oebad, 0);
        check({tag, " R6 idle oe/miso"}, {spi_miso_oe, spi_miso}, 2'b00);
        if (n > 0 && n % 8 == 0) begin
            model_commit(last);
            check({tag, " R4 registers after valid frame"}, {cfg_oc, cfg_diag, cfg_drv, cfg_en, cfg_wd, uv_dis, ov_dis}, model_cfg());
        end else begin
            check({tag, " R5 registers after invalid frame"}, {cfg_oc, cfg_diag, cfg_drv, cfg_en, cfg_wd, uv_dis, ov_dis}, model_cfg());
        end
    endtask

    function automatic logic [7:0] cmd(input logic c, input logic [2:0] a, input logic [3:0] d);
        return {c, a, d};
    endfunction

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_oc[k] = 0; m_diag[k] = 0; m_drv[k] = 0;
        end
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R11: reset state.
        check("R11 reset registers", {cfg_oc, cfg_diag, cfg_drv, cfg_en, cfg_wd, uv_dis, ov_dis}, 33'h0);
        check("R6 reset idle", {spi_miso_oe, spi_miso}, 2'b00);

        ch_flags = 8'b1010_0100; pin_lvl = 4'b1001; wd_timeout = 1'b1;
        xfer(8, 8'h00, cmd(0, 3'd7, 4'h0), "R11 first readback");

        // R4/R7: write every register address, both channels, spread data.
        for (int a = 1; a <= 6; a++)
            for (int c = 0; c < 2; c++)
                for (int d = 0; d < 16; d += 5)
                    xfer(8, 8'h00, cmd(c[0], a[2:0], d[3:0]), "R4 sweep");

        // R8/R7: every select row for both channels.
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 2; c++) begin
                xfer(8, 8'h00, cmd(c[0], 3'd0, {1'b0, s[2:0]}), "R8 set select");
                xfer(8, 8'h00, cmd(c[0], 3'd7, 4'h0), "R7 row readback");
                xfer(8, 8'h00, cmd(~c[0], 3'd4, 4'h6), "R11 select persists");
                xfer(8, 8'h00, cmd(c[0], 3'd7, 4'h0), "R11 select persists read");
            end

        // R9: mask combinations against voltage conditions in the fault row.
        xfer(8, 8'h00, cmd(0, 3'd0, 4'h0), "R9 select fault row");
        for (int m = 0; m < 4; m++) begin
            xfer(8, 8'h00, cmd(0, 3'd6, {2'b00, m[1:0]}), "R9 set mask");
            for (int v = 0; v < 4; v++) begin
                uv_flag = v[1]; ov_flag = v[0];
                ch_flags = (v == 0) ? 8'h00 : 8'h5A;
                tick(4);
                xfer(8, 8'h00, cmd(v[0], 3'd7, 4'h0), "R9 masked fault");
            end
        end
        xfer(8, 8'h00, cmd(0, 3'd6, 4'h0), "R9 unmask");

        // R5: invalid lengths, each carrying a write that must not land.
        xfer(0, 8'h00, 8'h00, "R5 empty frame");
        xfer(3, cmd(1, 3'd1, 4'hF), cmd(1, 3'd1, 4'hF), "R5 3-bit frame");
        xfer(7, cmd(1, 3'd0, 4'h5), cmd(1, 3'd0, 4'h5), "R5 7-bit frame");
        xfer(12, cmd(1, 3'd4, 4'hF), cmd(1, 3'd4, 4'hF), "R5 12-bit frame");
        xfer(15, cmd(1, 3'd6, 4'h3), cmd(1, 3'd6, 4'h3), "R5 15-bit frame");
        xfer(8, 8'h00, cmd(0, 3'd7, 4'h0), "R5 readback as if untouched");

        // R4/R3: multi-byte frame, only the last byte commits.
        xfer(24, cmd(0, 3'd1, 4'hF), cmd(1, 3'd1, 4'h3), "R4 24-bit frame");
        xfer(16, cmd(1, 3'd0, 4'h2), cmd(0, 3'd0, 4'h1), "R4 16-bit frame select");
        xfer(8, 8'h00, cmd(1, 3'd7, 4'h0), "R4 readback after 16-bit");

        // R10: long frames past the byte counter range.
        xfer(520, cmd(0, 3'd7, 4'h0), cmd(0, 3'd4, 4'hA), "R10 520-bit frame");
        xfer(517, cmd(1, 3'd4, 4'h5), cmd(1, 3'd4, 4'h5), "R10 517-bit frame");
        xfer(8, 8'h00, cmd(0, 3'd7, 4'h0), "R10 readback");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule